// File: doc/BRIEF.md
# Indirect Jump Target Fetch Unit

This block resolves the destination of a jump whose target is held in memory. A sequencer hands it a 16-bit pointer operand and a start strobe. The block then issues two single-byte reads. The first read returns the low byte of the target and the second returns the high byte. The block joins the two bytes into a new program counter value and reports it with a one-cycle done strobe. Opcode decode and the rest of the processor datapath are outside this block.

A build-time parameter selects the processor generation. The legacy variant copies an old page-wrap fault: when the pointer sits on the last byte of a page, the high byte is read from the start of that same page. The corrected variant lets the address carry into the next page. It spends one extra cycle on pointer preparation, and it also accepts an indexed form in which an index register is added to the pointer before the fetch. The legacy variant has no indexed form, so it finishes such a request as a no-op.

Top module: `ijmp_fetch`

## Requirements
- R1: While reset is held and after it is released, `done` is 0, `mem_rd` is 0 and `target` is 0x0000.
- R2: The first read presents the effective pointer E on `mem_addr` and the second read presents the high-byte address H. Read data returns one cycle after its address. `target` becomes {byte read at H, byte read at E}, with the high byte in bits 15:8.
- R3: Legacy variant (`CMOS_MODE`=0): H = {E[15:8], E[7:0]+1}, so a pointer whose low byte is 0xFF reads its high byte at offset 0x00 of the same page.
- R4: Corrected variant (`CMOS_MODE`=1): H = E+1 modulo 2^16, carrying into the next page (0xFFFF wraps to 0x0000).
- R5: When start is sampled at rising edge k, `done` is first high after edge k+3 in the legacy variant and after edge k+4 in the corrected variant, so the corrected variant is one cycle slower.
- R6: Corrected variant with `indexed`=1: E = `ptr` + zero-extended `idx`, modulo 2^16, with the carry propagating across the page.
- R7: Legacy variant with `indexed`=1: no read is issued, `done` is high after edge k+1, and `target` keeps its previous value.
- R8: `done` is high for exactly one cycle per accepted request. `target` changes only at the edge where `done` rises and otherwise holds its value.
- R9: A start strobe sampled while a request is in progress is ignored. The running request completes with its own operands and no second done follows.
- R10: Corrected variant with `indexed`=0: E = `ptr`, and `idx` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled only while idle |
| indexed | input | 1 | 1 selects the indexed form (pointer plus index) |
| ptr | input | 16 | Pointer operand: address of the target low byte |
| idx | input | 8 | Index value added in the indexed form |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read enable; data is expected on `mem_data` in the next cycle |
| mem_data | input | 8 | Read data |
| done | output | 1 | One-cycle strobe: `target` is valid |
| target | output | 16 | Assembled jump target, held until the next completion |

## Verification
The bench runs both variants side by side against a memory in which every byte depends on its own page number. A high-byte read from the wrong page therefore gives a different target. A pointer ending in 0xFF, and the address 0xFFFF, separate the legacy same-page wrap from the corrected carry. A design that applied the wrong rule would return a target whose high byte comes from the other page. Indexed requests whose sum crosses a page, or lands on a 0xFF offset, catch an adder that drops its carry. The same requests also show whether the legacy build wrongly issues reads or changes `target` instead of rejecting. Done latency is counted per variant. A strobe is injected mid-request to catch a design that restarts or emits a second done. The `target` output is watched for several idle cycles after completion to confirm that it holds.

// File: rtl/ijmp_pkg.sv
package ijmp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADJ  = 3'd1,
      ST_RDLO = 3'd2,
      ST_RDHI = 3'd3,
      ST_CAP  = 3'd4,
      ST_REJ  = 3'd5
   } ijmp_state_e;

endpackage

// File: rtl/ijmp_ptr_calc.sv
module ijmp_ptr_calc #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned IDX_W     = 8,
   parameter bit          CMOS_MODE = 1'b1
) (
   input  logic [ADDR_W-1:0] ptr,
   input  logic [IDX_W-1:0]  idx,
   input  logic              indexed,
   output logic [ADDR_W-1:0] eff
);

   generate
      if (CMOS_MODE) begin : g_cmos
         // indexed form: full-width add, carry crosses pages
         always_comb begin
            if (indexed) eff = ptr + ADDR_W'(idx);
            else         eff = ptr;
         end
      end else begin : g_nmos
         // no indexed form; the sequencer rejects it before this is used
         assign eff = ptr;
      end
   endgenerate

endmodule

// File: rtl/ijmp_hi_addr.sv
module ijmp_hi_addr #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned PAGE_W    = 8,
   parameter bit          CMOS_MODE = 1'b1
) (
   input  logic [ADDR_W-1:0] lo_addr,
   output logic [ADDR_W-1:0] hi_addr
);

   generate
      if (CMOS_MODE) begin : g_carry
         assign hi_addr = lo_addr + ADDR_W'(1);
      end else begin : g_wrap
         // increment only the in-page offset; the page number never moves
         assign hi_addr = {lo_addr[ADDR_W-1:PAGE_W],
                           lo_addr[PAGE_W-1:0] + PAGE_W'(1)};
      end
   endgenerate

endmodule

// File: rtl/ijmp_ctrl.sv
module ijmp_ctrl
   import ijmp_pkg::*;
#(
   parameter bit CMOS_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic indexed,
   output logic load_op,
   output logic load_eff,
   output logic rd_lo,
   output logic rd_hi,
   output logic cap_lo,
   output logic cap_hi,
   output logic done
);

   ijmp_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               if (!CMOS_MODE && indexed) state_d = ST_REJ;
               else if (CMOS_MODE)        state_d = ST_ADJ;
               else                       state_d = ST_RDLO;
            end
         end
         ST_ADJ:  state_d = ST_RDLO;
         ST_RDLO: state_d = ST_RDHI;
         ST_RDHI: state_d = ST_CAP;
         ST_CAP:  state_d = ST_IDLE;
         ST_REJ:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done    <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= (state_q == ST_CAP) || (state_q == ST_REJ);
      end
   end

   assign load_op  = (state_q == ST_IDLE) && start;
   assign load_eff = (state_q == ST_ADJ);
   assign rd_lo    = (state_q == ST_RDLO);
   assign rd_hi    = (state_q == ST_RDHI);
   // data lags its address by one cycle
   assign cap_lo   = (state_q == ST_RDHI);
   assign cap_hi   = (state_q == ST_CAP);

endmodule

// File: rtl/ijmp_fetch.sv
module ijmp_fetch #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned IDX_W     = 8,
   parameter int unsigned PAGE_W    = 8,
   parameter bit          CMOS_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              indexed,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_data,
   output logic              done,
   output logic [ADDR_W-1:0] target
);

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("ijmp_fetch: ADDR_W must equal two data bytes");
      end
      if (PAGE_W == 0 || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("ijmp_fetch: PAGE_W must lie between 1 and ADDR_W-1");
      end
      if (IDX_W == 0 || IDX_W > ADDR_W) begin : g_bad_idx
         $error("ijmp_fetch: IDX_W must lie between 1 and ADDR_W");
      end
   endgenerate

   logic load_op, load_eff, rd_lo, rd_hi, cap_lo, cap_hi;

   ijmp_ctrl #(.CMOS_MODE(CMOS_MODE)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .indexed  (indexed),
      .load_op  (load_op),
      .load_eff (load_eff),
      .rd_lo    (rd_lo),
      .rd_hi    (rd_hi),
      .cap_lo   (cap_lo),
      .cap_hi   (cap_hi),
      .done     (done)
   );

   logic [ADDR_W-1:0] ptr_q;
   logic [IDX_W-1:0]  idx_q;
   logic              ind_q;
   logic [DATA_W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         idx_q <= '0;
         ind_q <= 1'b0;
      end else if (load_op) begin
         ptr_q <= ptr;
         idx_q <= idx;
         ind_q <= indexed;
      end
   end

   logic [ADDR_W-1:0] eff_c, eff_use, hi_c;

   ijmp_ptr_calc #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CMOS_MODE(CMOS_MODE)
   ) u_calc (
      .ptr     (ptr_q),
      .idx     (idx_q),
      .indexed (ind_q),
      .eff     (eff_c)
   );

   generate
      if (CMOS_MODE) begin : g_eff_reg
         // the extra cycle: the index sum is registered before the first read
         logic [ADDR_W-1:0] eff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        eff_q <= '0;
            else if (load_eff) eff_q <= eff_c;
         end
         assign eff_use = eff_q;
      end else begin : g_eff_direct
         assign eff_use = eff_c;
      end
   endgenerate

   ijmp_hi_addr #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CMOS_MODE(CMOS_MODE)
   ) u_hi (
      .lo_addr (eff_use),
      .hi_addr (hi_c)
   );

   assign mem_addr = rd_hi ? hi_c : eff_use;
   assign mem_rd   = rd_lo | rd_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         target <= '0;
      end else begin
         if (cap_lo) lo_q   <= mem_data;
         if (cap_hi) target <= {mem_data, lo_q};
      end
   end

endmodule

// File: rtl/ijmp_fetch_chk.sv
module ijmp_fetch_chk #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned PAGE_W    = 8,
   parameter bit          CMOS_MODE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic              mem_rd,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] target
);

   // R8: completion strobe lasts one cycle
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: target moves only together with done
   a_r8_target_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(target));

   // R2: exactly two reads back to back per request
   a_r2_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && $past(mem_rd)) |=> !mem_rd);

   // R5: no read is still outstanding when done is reported
   a_r5_no_read_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> !done);

   generate
      if (CMOS_MODE) begin : g_carry_chk
         // R4: second address is the first plus one across pages
         a_r4_page_carry: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
      end else begin : g_wrap_chk
         // R3: second address stays in the page of the first
         a_r3_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_rd && $past(mem_rd)) |->
               ((mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])) &&
                (mem_addr[PAGE_W-1:0] == $past(mem_addr[PAGE_W-1:0]) + PAGE_W'(1))));
      end
   endgenerate

endmodule

bind ijmp_fetch ijmp_fetch_chk #(
   .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CMOS_MODE(CMOS_MODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .done     (done),
   .mem_rd   (mem_rd),
   .mem_addr (mem_addr),
   .target   (target)
);

// File: tb/ijmp_fetch_test.sv
`timescale 1ns/1ps
module ijmp_fetch_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        indexed = 1'b0;
   logic [15:0] ptr = '0;
   logic [7:0]  idx = '0;

   logic [15:0] addr_c, addr_n, tgt_c, tgt_n;
   logic        rd_c, rd_n, done_c, done_n;
   logic [7:0]  data_c = '0;
   logic [7:0]  data_n = '0;

   int n_checks = 0;
   int n_fail   = 0;
   int rdcnt_c  = 0;
   int rdcnt_n  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   ijmp_fetch #(.CMOS_MODE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .indexed(indexed),
      .ptr(ptr), .idx(idx), .mem_addr(addr_c), .mem_rd(rd_c),
      .mem_data(data_c), .done(done_c), .target(tgt_c)
   );

   ijmp_fetch #(.CMOS_MODE(1'b0)) uut_nm (
      .clk(clk), .rst_n(rst_n), .start(start), .indexed(indexed),
      .ptr(ptr), .idx(idx), .mem_addr(addr_n), .mem_rd(rd_n),
      .mem_data(data_n), .done(done_n), .target(tgt_n)
   );

   // byte content depends on both page and offset
   function automatic logic [7:0] memf(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
   endfunction

   always_ff @(posedge clk) begin
      data_c <= memf(addr_c);
      data_n <= memf(addr_n);
      if (rd_c) rdcnt_c <= rdcnt_c + 1;
      if (rd_n) rdcnt_n <= rdcnt_n + 1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] tgt_of(input logic [15:0] e, input bit cm);
      logic [15:0] h;
      h = cm ? e + 16'd1 : {e[15:8], e[7:0] + 8'd1};
      return {memf(h), memf(e)};
   endfunction

   // one request to both variants; optional strobe injected mid-request
   task automatic run(input string tag, input logic [15:0] p, input logic [7:0] i,
                      input bit ind, input bit busy, input logic [15:0] bp);
      int lat_c = 0, lat_n = 0, cnt_c = 0, cnt_n = 0;
      int rc0, rn0;
      logic [15:0] eff, old_n, exp_n;
      eff   = ind ? p + {8'd0, i} : p;
      old_n = tgt_n;
      exp_n = ind ? old_n : tgt_of(p, 1'b0);
      @(negedge clk);
      rc0 = rdcnt_c; rn0 = rdcnt_n;
      ptr = p; idx = i; indexed = ind; start = 1'b1;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         if (k == 1) start = 1'b0;
         if (busy && k == 2) begin ptr = bp; idx = 8'h00; indexed = 1'b0; start = 1'b1; end
         if (busy && k == 3) start = 1'b0;
         if (done_c) begin cnt_c++; if (lat_c == 0) lat_c = k; end
         if (done_n) begin cnt_n++; if (lat_n == 0) lat_n = k; end
      end
      chk({tag, " R2 target cmos"}, tgt_c, tgt_of(eff, 1'b1));
      chk({tag, " R5 latency cmos"}, lat_c, 5);
      chk({tag, " R8 done count cmos"}, cnt_c, 1);
      chk({tag, " R2 reads cmos"}, rdcnt_c - rc0, 2);
      if (ind) begin
         chk({tag, " R7 target held nmos"}, tgt_n, exp_n);
         chk({tag, " R7 latency nmos"}, lat_n, 2);
         chk({tag, " R7 no reads nmos"}, rdcnt_n - rn0, 0);
      end else begin
         chk({tag, " R2 target nmos"}, tgt_n, exp_n);
         chk({tag, " R5 latency nmos"}, lat_n, 4);
         chk({tag, " R2 reads nmos"}, rdcnt_n - rn0, 2);
      end
      chk({tag, " R8 done count nmos"}, cnt_n, 1);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 done during reset", {done_c, done_n}, 0);
      chk("R1 rd during reset", {rd_c, rd_n}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 target after reset", {tgt_c, tgt_n}, 0);
      chk("R1 done after reset", {done_c, done_n}, 0);
   endtask

   task automatic t_hold;
      logic [15:0] hc, hn;
      hc = tgt_c; hn = tgt_n;
      ptr = 16'hBEEF; idx = 8'h11;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R8 target holds cmos", tgt_c, hc);
         chk("R8 target holds nmos", tgt_n, hn);
         chk("R8 done stays low", {done_c, done_n}, 0);
      end
   endtask

   initial begin
      #(8 * 100000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      run("plain", 16'h1234, 8'h00, 1'b0, 1'b0, 16'h0);
      run("R3 R4 page end", 16'h19FF, 8'h00, 1'b0, 1'b0, 16'h0);
      run("R4 top of space", 16'hFFFF, 8'h00, 1'b0, 1'b0, 16'h0);
      run("R6 R7 indexed carry", 16'h20F0, 8'h20, 1'b1, 1'b0, 16'h0);
      run("R6 indexed to FF", 16'h30F0, 8'h0F, 1'b1, 1'b0, 16'h0);
      run("R10 idx ignored", 16'h4080, 8'h55, 1'b0, 1'b0, 16'h0);
      run("R9 busy start", 16'h5A10, 8'h00, 1'b0, 1'b1, 16'h7700);
      t_hold();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule